// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer execution unit that treats its operands either as one full 64-bit word or as a row of independent lanes of 32, 16 or 8 bits. The lane size is chosen for each operation. Addition, subtraction, the three shift kinds and the bitwise operations work at every lane size. Multiplication works only on 16-bit and 8-bit lanes, and each lane keeps the low half of its own product. Carries, borrows and shifted-out bits never pass from one lane into the next.

The second operand can be replaced by an 8-bit constant. The constant is widened by sign or zero extension, cut to the lane width and copied into every lane. Each accepted operation produces a registered result and a valid strobe one clock later. An opcode and lane combination that the unit does not support yields a zero result and sets an illegal flag. The block has no internal sequencing state. Its only state is the output register stage, which is either idle after reset or holds the most recently accepted operation.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operation, `out_valid`, `result` and `illegal` are all 0.
- R2: `op`=0 (add) computes a+b separately in each lane, modulo the lane width. The lane codes are `lane_sel`=0 for one 64-bit lane, 1 for 32-bit, 2 for 16-bit and 3 for 8-bit. No carry crosses a lane boundary.
- R3: `op`=1 (subtract) computes a-b separately in each lane, modulo the lane width, and no borrow crosses a lane boundary.
- R4: `op`=2, 3 and 4 produce the bitwise AND, OR and XOR of the two operands, and the lane size has no effect on the result.
- R5: `op`=5 shifts left and `op`=6 shifts right logically. Each lane is shifted by the low log2(lane width) bits of the second operand, so the amount is taken modulo the lane width, and every lane uses the same amount.
- R6: `op`=7 shifts right arithmetically, filling each lane with that lane's own sign bit.
- R7: `op`=8 multiplies the matching 16-bit lanes (`lane_sel`=2) or 8-bit lanes (`lane_sel`=3) and writes the low half of each product into the same lane.
- R8: When `imm_en`=1, the second operand is replaced. `imm_val` is extended to 64 bits, by sign extension if `imm_signed`=1 and by zero extension otherwise, then truncated to the lane width and replicated into every lane.
- R9: `op`=8 with `lane_sel`=0 or 1, and any `op` value from 9 to 15, give `result`=0 with `illegal`=1. Every legal operation gives `illegal`=0.
- R10: An operation presented with `in_valid`=1 appears on `result` and `illegal` exactly one cycle later, with `out_valid`=1 in that cycle. In a cycle with `in_valid`=0, the next cycle has `out_valid`=0 and `result` and `illegal` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 sra, 8 mul |
| lane_sel | input | 2 | Lane size: 0=64, 1=32, 2=16, 3=8 bits |
| a | input | 64 | First operand |
| b | input | 64 | Second operand (ignored when imm_en=1) |
| imm_en | input | 1 | Use the immediate as the second operand |
| imm_val | input | 8 | 8-bit immediate constant |
| imm_signed | input | 1 | 1 = sign-extend the immediate, 0 = zero-extend it |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Registered lane-wise result |
| illegal | output | 1 | Unsupported opcode or lane combination |

## Verification
The only state is the output register stage, so a fault in it shows up within one cycle. A lost or extra strobe appears as a wrong `out_valid`. A register that loads while `in_valid` is low changes `result` in an idle cycle. A wrong lane-boundary decision in the datapath shows up as a carry, borrow or sign bit leaking into the neighbouring lane, and it is visible on the very next result. The directed vectors place all-ones and sign-bit patterns exactly at lane edges so that such a leak changes a bit the expected value pins down.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SRA = 4'd7,
        OP_MUL = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        LANE_64 = 2'd0,
        LANE_32 = 2'd1,
        LANE_16 = 2'd2,
        LANE_8  = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_e;

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        lane,
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    localparam int NCHUNK = DATA_W / 8;

    // Chunk k begins a new lane when its byte index is aligned to the lane size.
    function automatic logic lane_start(input int k, input logic [1:0] l);
        unique case (l)
            LANE_8:  lane_start = 1'b1;
            LANE_16: lane_start = (k % 2) == 0;
            LANE_32: lane_start = (k % 4) == 0;
            default: lane_start = (k % 8) == 0;
        endcase
    endfunction

    always_comb begin
        logic       carry;
        logic [8:0] part;
        carry = sub;
        sum   = '0;
        for (int k = 0; k < NCHUNK; k++) begin
            if (lane_start(k, lane)) begin
                carry = sub;
            end
            part = {1'b0, a[k*8 +: 8]} + {1'b0, b[k*8 +: 8] ^ {8{sub}}} + {8'd0, carry};
            sum[k*8 +: 8] = part[7:0];
            carry = part[8];
        end
    end

endmodule

// File: rtl/simd_shift.sv
module simd_shift
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        lane,
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] a,
    input  logic [5:0]        amt,
    output logic [DATA_W-1:0] y
);
    logic [3:0][DATA_W-1:0] per_mode;

    for (genvar g = 0; g < 4; g++) begin : g_mode
        localparam int W     = 64 >> g;
        localparam int NLANE = DATA_W / W;
        localparam int SW    = $clog2(W);
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            logic        [W-1:0]  x;
            logic signed [W-1:0]  xs;
            logic        [SW-1:0] sh;
            logic        [W-1:0]  arith;
            assign x     = a[i*W +: W];
            assign xs    = x;
            assign sh    = amt[SW-1:0];
            assign arith = xs >>> sh;
            always_comb begin
                unique case (kind)
                    SH_LEFT:  per_mode[g][i*W +: W] = x << sh;
                    SH_RIGHT: per_mode[g][i*W +: W] = x >> sh;
                    default:  per_mode[g][i*W +: W] = arith;
                endcase
            end
        end
    end

    assign y = per_mode[lane];

endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [1:0][DATA_W-1:0] prod;

    // prod[0]: 16-bit lanes, prod[1]: 8-bit lanes
    for (genvar g = 0; g < 2; g++) begin : g_size
        localparam int W     = 16 >> g;
        localparam int NLANE = DATA_W / W;
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            logic [W-1:0] pa, pb;
            assign pa = a[i*W +: W];
            assign pb = b[i*W +: W];
            assign prod[g][i*W +: W] = pa * pb;
        end
    end

    always_comb begin
        unique case (lane)
            LANE_16: y = prod[0];
            LANE_8:  y = prod[1];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              imm_en,
    input  logic [7:0]        imm_val,
    input  logic              imm_signed,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int N32 = DATA_W / 32;
    localparam int N16 = DATA_W / 16;
    localparam int N8  = DATA_W / 8;

    // Immediate widening and lane replication
    logic [63:0]       imm_ext;
    logic [DATA_W-1:0] imm_rep;
    logic [DATA_W-1:0] opnd_b;

    assign imm_ext = imm_signed ? {{56{imm_val[7]}}, imm_val} : {56'd0, imm_val};

    always_comb begin
        unique case (lane_sel)
            LANE_8:  imm_rep = {N8{imm_ext[7:0]}};
            LANE_16: imm_rep = {N16{imm_ext[15:0]}};
            LANE_32: imm_rep = {N32{imm_ext[31:0]}};
            default: imm_rep = {(DATA_W/64){imm_ext}};
        endcase
    end

    assign opnd_b = imm_en ? imm_rep : b;

    // Datapath units
    logic [DATA_W-1:0] sum_w, shf_w, mul_w;
    logic [1:0]        sh_kind;

    always_comb begin
        unique case (op)
            OP_SLL:  sh_kind = SH_LEFT;
            OP_SRL:  sh_kind = SH_RIGHT;
            default: sh_kind = SH_ARITH;
        endcase
    end

    simd_addsub #(.DATA_W(DATA_W)) u_addsub (
        .lane (lane_sel),
        .sub  (op == OP_SUB),
        .a    (a),
        .b    (opnd_b),
        .sum  (sum_w)
    );

    simd_shift #(.DATA_W(DATA_W)) u_shift (
        .lane (lane_sel),
        .kind (sh_kind),
        .a    (a),
        .amt  (opnd_b[5:0]),
        .y    (shf_w)
    );

    simd_mul #(.DATA_W(DATA_W)) u_mul (
        .lane (lane_sel),
        .a    (a),
        .b    (opnd_b),
        .y    (mul_w)
    );

    // Result selection and legality
    logic              bad_c;
    logic [DATA_W-1:0] res_c;

    always_comb begin
        bad_c = 1'b0;
        res_c = '0;
        unique case (op)
            OP_ADD, OP_SUB:         res_c = sum_w;
            OP_AND:                 res_c = a & opnd_b;
            OP_OR:                  res_c = a | opnd_b;
            OP_XOR:                 res_c = a ^ opnd_b;
            OP_SLL, OP_SRL, OP_SRA: res_c = shf_w;
            OP_MUL: begin
                if (lane_sel == LANE_16 || lane_sel == LANE_8) begin
                    res_c = mul_w;
                end else begin
                    bad_c = 1'b1;
                end
            end
            default:                bad_c = 1'b1;
        endcase
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= bad_c ? '0 : res_c;
                illegal <= bad_c;
            end
        end
    end

    // Assertions
    p_strobe_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    p_illegal_is_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == '0);
    p_wide_mul_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MUL && (lane_sel == LANE_64 || lane_sel == LANE_32)) |=> illegal);
    p_xor_lane_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_XOR && !imm_en) |=> (result == ($past(a) ^ $past(b)) && !illegal));

endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [1:0]  lane_sel;
    logic [63:0] a, b;
    logic        imm_en;
    logic [7:0]  imm_val;
    logic        imm_signed;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
        .a(a), .b(b), .imm_en(imm_en), .imm_val(imm_val), .imm_signed(imm_signed),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model written from the requirements
    function automatic logic [63:0] model(input int o, input int l, input logic [63:0] x_a,
                                          input logic [63:0] x_b, input bit ie,
                                          input logic [7:0] iv, input bit is);
        int w = 64 >> l;
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] bb, e, res, x, y, r, sh;
        bb = x_b;
        if (ie) begin
            e  = is ? {{56{iv[7]}}, iv} : {56'd0, iv};
            e  = e & m;
            bb = '0;
            for (int k = 0; k < 64 / w; k++) bb = bb | (e << (k * w));
        end
        if (o > 8 || (o == 8 && w > 16)) return '0;
        sh  = bb & 64'(w - 1);
        res = '0;
        for (int k = 0; k < 64 / w; k++) begin
            x = (x_a >> (k * w)) & m;
            y = (bb >> (k * w)) & m;
            case (o)
                0: r = x + y;
                1: r = x - y;
                2: r = x & y;
                3: r = x | y;
                4: r = x ^ y;
                5: r = x << sh;
                6: r = x >> sh;
                7: begin
                    if (x[w-1]) x = x | ~m;
                    r = $signed(x) >>> sh;
                end
                default: r = x * y;
            endcase
            res = res | ((r & m) << (k * w));
        end
        return res;
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5, 6: return "R5";
            7: return "R6";
            8: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input string req, input int o, input int l, input logic [63:0] x_a,
                         input logic [63:0] x_b, input bit ie, input logic [7:0] iv, input bit is);
        logic [63:0] exp;
        bit bad;
        exp = model(o, l, x_a, x_b, ie, iv, is);
        bad = (o > 8) || (o == 8 && l < 2);
        @(negedge clk);
        in_valid = 1'b1; op = 4'(o); lane_sel = 2'(l); a = x_a; b = x_b;
        imm_en = ie; imm_val = iv; imm_signed = is;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, exp);
        check({req, " illegal"}, {63'd0, illegal}, {63'd0, bad});
        check("R10 strobe", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; op = 4'd0; lane_sel = 2'd0;
        a = '1; b = '1; imm_en = 1'b0; imm_val = 8'd0; imm_signed = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 result in reset", result, 64'd0);
        check("R1 strobe in reset", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe after reset", {63'd0, out_valid}, 64'd0);
        check("R1 illegal after reset", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_add;
        apply("R2 add64 carry chain", 0, 0, '1, 64'd1, 0, 0, 0);
        apply("R2 add32 cut", 0, 1, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0);
        apply("R2 add16 cut", 0, 2, 64'h00FF_FFFF_00FF_FFFF, 64'h0001_0001_0001_0001, 0, 0, 0);
        check("R2 add16 literal", result, 64'h0100_0000_0100_0000);
        apply("R2 add8 cut", 0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0);
        check("R2 add8 literal", result, 64'd0);
    endtask

    task automatic t_sub;
        apply("R3 sub64", 0 + 1, 0, 64'd0, 64'd1, 0, 0, 0);
        apply("R3 sub16 borrow cut", 1, 2, 64'h0000_1000_0000_0001, 64'h0001_0001_0001_0001, 0, 0, 0);
        check("R3 sub16 literal", result, 64'hFFFF_0FFF_FFFF_0000);
        apply("R3 sub8", 1, 3, 64'h0080_0100_7F00_0001, 64'h0101_0101_0101_0101, 0, 0, 0);
    endtask

    task automatic t_logic;
        apply("R4 and", 2, 3, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_F0F0, 0, 0, 0);
        apply("R4 or", 3, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_F0F0, 0, 0, 0);
        apply("R4 xor", 4, 1, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_F0F0, 0, 0, 0);
    endtask

    task automatic t_shift;
        apply("R5 sll64", 5, 0, 64'h8000_0000_0000_0001, 64'd63, 0, 0, 0);
        apply("R5 sll8 mod width", 5, 3, 64'h8181_8181_8181_8181, 64'd9, 0, 0, 0);
        check("R5 sll8 literal", result, 64'h0202_0202_0202_0202);
        apply("R5 srl16", 6, 2, 64'h8000_8001_FFFF_0100, 64'd4, 0, 0, 0);
        apply("R5 srl32 mod width", 6, 1, 64'h8000_0000_0000_0010, 64'd36, 0, 0, 0);
    endtask

    task automatic t_sra;
        apply("R6 sra8 own sign", 7, 3, 64'h8000_7F80_0180_FF01, 64'd3, 0, 0, 0);
        check("R6 sra8 literal", result, 64'hF000_0FF0_00F0_FF00);
        apply("R6 sra64", 7, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 0, 0);
        apply("R6 sra32", 7, 1, 64'h7FFF_FFFF_8000_0000, 64'd31, 0, 0, 0);
    endtask

    task automatic t_mul;
        apply("R7 mul16", 8, 2, 64'h0100_FFFF_0003_1234, 64'h0100_FFFF_0005_0010, 0, 0, 0);
        check("R7 mul16 literal", result[31:0], 64'h0000_0000_000F_2340);
        apply("R7 mul8", 8, 3, 64'h1002_FF80_0310_0705, 64'h1003_FF02_0510_0709, 0, 0, 0);
    endtask

    task automatic t_imm;
        apply("R8 add8 sext", 0, 3, 64'h0102_0304_0506_0708, 64'hDEAD, 1, 8'hFF, 1);
        check("R8 add8 literal", result, 64'h0001_0203_0405_0607);
        apply("R8 add16 zext", 0, 2, 64'h0001_0001_0001_0001, '1, 1, 8'hFF, 0);
        check("R8 add16 literal", result, 64'h0100_0100_0100_0100);
        apply("R8 sub64 sext", 1, 0, 64'd5, 64'd0, 1, 8'h80, 1);
        apply("R8 and32 sext", 2, 1, '1, 64'd0, 1, 8'h81, 1);
        apply("R8 mul16 zext", 8, 2, 64'h0002_0003_0004_0005, '1, 1, 8'h90, 0);
    endtask

    task automatic t_illegal;
        apply("R9 mul64", 8, 0, '1, '1, 0, 0, 0);
        apply("R9 mul32", 8, 1, 64'h1234, 64'h5678, 0, 0, 0);
        apply("R9 op9", 9, 3, '1, '1, 0, 0, 0);
        apply("R9 op15", 15, 2, '1, '1, 0, 0, 0);
        apply("R9 legal after illegal", 0, 3, 64'h11, 64'h22, 0, 0, 0);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        apply("R10 load", 0, 0, 64'h1234, 64'h1111, 0, 0, 0);
        prev = result;
        @(negedge clk);
        a = '1; b = '1; op = 4'd8; lane_sel = 2'd0;
        @(negedge clk);
        check("R10 idle strobe", {63'd0, out_valid}, 64'd0);
        check("R10 idle hold result", result, prev);
        check("R10 idle hold illegal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_sweep;
        logic [63:0] s = 64'hACE1_2468_9BDF_1357;
        for (int n = 0; n < 300; n++) begin
            logic [63:0] va, vb;
            int o, l;
            s  = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
            va = s;
            s  = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
            vb = s ^ {s[31:0], s[63:32]};
            o  = n % 10;
            l  = (n / 10) % 4;
            apply(tag_of(o), o, l, va, vb, (n % 7) == 0, va[7:0], vb[0]);
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_sra();
        t_mul();
        t_imm();
        t_illegal();
        t_hold();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule